// File: doc/BRIEF.md
# Multi-Mode Timer Counter with Edge Control

The block is a programmable counter of `CNT_W` bits (16 by default) that runs between zero and a software-chosen top value. It counts up, down, or alternately up and down. It can run continuously or stop after its first wrap. The counter only advances on a tick. The tick comes from one of three sources: a free-running power-of-two divider of the block clock, a chosen edge on an external input, or the wrap pulse of a neighbouring counter. The third source lets several instances be chained into a wider timer.

A separate control input can change the run state in hardware. Its rising and falling edges each carry their own action: nothing, start, stop, or reload-and-start. Software can also start and stop the counter through plain command pins. The block reports the count, a counting-direction flag, and single-cycle overflow and underflow pulses. It has no streaming data path, so every pin is a plain level or a one-cycle pulse and none has back-pressure.

All inputs are taken to be synchronous to `clk`. Edges are found by comparing each input with its value one cycle earlier. A tick, command or action seen in one cycle takes effect at the next rising clock edge.

Top module: `mm_timer`

## Requirements
- R1: With mode 0 (up), each tick while running adds one to the count. A tick at a count at or above top sets the count to 0 and raises `ovf_o` instead.
- R2: With mode 1 (down), each tick while running subtracts one from the count. A tick at count 0 loads top and raises `unf_o` instead. `dir_down_o` is 1 in this mode.
- R3: With mode 2 (up/down), the count rises from 0 to top and then falls back to 0, repeating. The step from top to top-1 raises `ovf_o` and sets `dir_down_o`. The step from 0 to 1 raises `unf_o` and clears `dir_down_o`.
- R4: With source 0, a tick occurs once every 2^n clock cycles, where n is `cfg_presc_exp`. Any value above 10 acts as 10.
- R5: With source 1, a tick occurs on the edge of `ext_in` picked by `cfg_ext_edge`: 0 selects rising, 1 selects falling, 2 selects both.
- R6: With source 2, each cycle in which `casc_in` is high is one tick.
- R7: A rising edge of `ctl_in` applies the action in `cfg_act_rise`. A falling edge applies the action in `cfg_act_fall`. The action codes are 0 none, 1 start, 2 stop and 3 reload-and-start. Start and stop leave the count as it is.
- R8: A reload sets the count to top in down mode and to 0 otherwise, and clears the up/down direction. A tick in the reload cycle is discarded.
- R9: With `cfg_oneshot` high, the counter stops itself on the cycle that raises `ovf_o` or `unf_o`.
- R10: `cmd_start` and `cmd_stop` change the run state at the next clock edge, with stop winning over start. A hardware action in the same cycle overrides both. A tick advances the count only if the counter was already running before that edge. While stopped, the count holds.
- R11: `ovf_o` and `unf_o` are registered pulses that appear in the same cycle as the wrapped count. They are never high together. After reset the count is 0, the counter is stopped and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 0 up, 1 down, 2 up/down (3 behaves as up) |
| cfg_oneshot | input | 1 | 1 stops the counter after its first wrap |
| cfg_src | input | 2 | Tick source: 0 divider, 1 external edge, 2 neighbour pulse, 3 none |
| cfg_presc_exp | input | 4 | Divider exponent n, so one tick per 2^n cycles, clipped to 10 |
| cfg_ext_edge | input | 2 | External edge select: 0 rising, 1 falling, 2 both |
| cfg_act_rise | input | 2 | Action on a rising edge of `ctl_in` |
| cfg_act_fall | input | 2 | Action on a falling edge of `ctl_in` |
| cfg_top | input | CNT_W | Top value |
| cmd_start | input | 1 | Software start command |
| cmd_stop | input | 1 | Software stop command |
| ext_in | input | 1 | External tick input |
| ctl_in | input | 1 | Hardware run-control input |
| casc_in | input | 1 | Wrap pulse from the neighbouring counter |
| count_o | output | CNT_W | Current count |
| dir_down_o | output | 1 | 1 while counting downward |
| ovf_o | output | 1 | One-cycle overflow pulse |
| unf_o | output | 1 | One-cycle underflow pulse |

## Verification
A hardware edge action on `ctl_in` can land in the same cycle as a software command. The bench provokes this by raising `ctl_in` (with a stop action) in the same cycle as `cmd_start`. It then checks that the count stays frozen for several cycles, which shows the hardware stop prevailed. A reload can also coincide with a tick, because the divider ticks every cycle with exponent 0. Every table vector starts from such a reload, and the expected counts assume the tick in the reload cycle is discarded.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {MD_UP = 2'd0, MD_DOWN = 2'd1, MD_UPDN = 2'd2, MD_RSV = 2'd3} mode_e;
  typedef enum logic [1:0] {SRC_DIV = 2'd0, SRC_EXT = 2'd1, SRC_CASC = 2'd2, SRC_OFF = 2'd3} src_e;
  typedef enum logic [1:0] {ACT_NONE = 2'd0, ACT_START = 2'd1, ACT_STOP = 2'd2, ACT_RELOAD = 2'd3} act_e;
  typedef enum logic [1:0] {EDG_RISE = 2'd0, EDG_FALL = 2'd1, EDG_BOTH = 2'd2, EDG_RSV = 2'd3} edge_e;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
#(
  parameter int PRESC_MAX = 10,
  parameter int PEXP_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  src_e              src,
  input  logic [PEXP_W-1:0] presc_exp,
  input  edge_e             ext_edge,
  input  logic              ext_in,
  input  logic              casc_in,
  output logic              tick
);
  localparam int PW = PRESC_MAX;

  logic [PW-1:0]     div_q;
  logic [PEXP_W-1:0] exp_eff;
  logic [PW:0]       shifted;
  logic [PW-1:0]     mask;
  logic              ext_q, ext_rise, ext_fall, ext_hit, div_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ext_q <= 1'b0;
    end else begin
      div_q <= div_q + PW'(1);
      ext_q <= ext_in;
    end
  end

  always_comb begin
    exp_eff = (presc_exp > PEXP_W'(PRESC_MAX)) ? PEXP_W'(PRESC_MAX) : presc_exp;
    shifted = (PW + 1)'(1) << exp_eff;
    mask    = shifted[PW-1:0] - PW'(1);
    div_hit = ((div_q & mask) == mask);
    ext_rise = ext_in & ~ext_q;
    ext_fall = ~ext_in & ext_q;
    case (ext_edge)
      EDG_RISE: ext_hit = ext_rise;
      EDG_FALL: ext_hit = ext_fall;
      EDG_BOTH: ext_hit = ext_rise | ext_fall;
      default:  ext_hit = 1'b0;
    endcase
    case (src)
      SRC_DIV:  tick = div_hit;
      SRC_EXT:  tick = ext_hit;
      SRC_CASC: tick = casc_in;
      default:  tick = 1'b0;
    endcase
  end

  // R4: with a divide ratio of at least two, ticks never come back to back
  assert_div_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_DIV && $past(src) == SRC_DIV && presc_exp != '0 &&
     $stable(presc_exp) && $past(tick)) |-> !tick);
endmodule

// File: rtl/tmr_edge_ctl.sv
module tmr_edge_ctl
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_in,
  input  act_e act_rise,
  input  act_e act_fall,
  output act_e hw_act
);
  logic ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= 1'b0;
    else        ctl_q <= ctl_in;
  end

  always_comb begin
    if (ctl_in && !ctl_q)      hw_act = act_rise;
    else if (!ctl_in && ctl_q) hw_act = act_fall;
    else                       hw_act = ACT_NONE;
  end

  // R7: an action only appears where the control input has just changed
  assert_act_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_act != ACT_NONE) |-> (ctl_in != ctl_q));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mode_e        mode,
  input  logic         oneshot,
  input  logic [W-1:0] top,
  input  logic         tick,
  input  act_e         hw_act,
  input  logic         sw_start,
  input  logic         sw_stop,
  output logic [W-1:0] cnt_o,
  output logic         dir_down_o,
  output logic         ovf_o,
  output logic         unf_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, run_d, dir_q, dir_d;
  logic         ovf_q, unf_q, ev_ovf, ev_unf, reload, step;

  always_comb begin
    reload = (hw_act == ACT_RELOAD);
    step   = run_q && tick && !reload;
    cnt_d  = cnt_q;
    dir_d  = dir_q;
    ev_ovf = 1'b0;
    ev_unf = 1'b0;
    if (reload) begin
      cnt_d = (mode == MD_DOWN) ? top : '0;
      dir_d = 1'b0;
    end else if (step) begin
      case (mode)
        MD_DOWN: begin
          if (cnt_q == '0) begin
            cnt_d  = top;
            ev_unf = 1'b1;
          end else cnt_d = cnt_q - ONE;
        end
        MD_UPDN: begin
          if (top == '0) cnt_d = '0;
          else if (!dir_q) begin
            if (cnt_q >= top) begin
              cnt_d  = top - ONE;
              dir_d  = 1'b1;
              ev_ovf = 1'b1;
            end else cnt_d = cnt_q + ONE;
          end else begin
            if (cnt_q == '0) begin
              cnt_d  = ONE;
              dir_d  = 1'b0;
              ev_unf = 1'b1;
            end else cnt_d = cnt_q - ONE;
          end
        end
        default: begin
          if (cnt_q >= top) begin
            cnt_d  = '0;
            ev_ovf = 1'b1;
          end else cnt_d = cnt_q + ONE;
        end
      endcase
    end
    case (hw_act)
      ACT_START, ACT_RELOAD: run_d = 1'b1;
      ACT_STOP:              run_d = 1'b0;
      default: begin
        if (sw_stop)                         run_d = 1'b0;
        else if (sw_start)                   run_d = 1'b1;
        else if (oneshot && (ev_ovf || ev_unf)) run_d = 1'b0;
        else                                 run_d = run_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      dir_q <= 1'b0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      dir_q <= dir_d;
      ovf_q <= ev_ovf;
      unf_q <= ev_unf;
    end
  end

  assign cnt_o      = cnt_q;
  assign ovf_o      = ovf_q;
  assign unf_o      = unf_q;
  assign dir_down_o = (mode == MD_DOWN) ? 1'b1 : (mode == MD_UPDN) ? dir_q : 1'b0;

  // R1: an up-mode overflow always lands on zero
  assert_up_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && mode == MD_UP && $past(mode) == MD_UP) |-> (cnt_q == '0));

  // R2: a down-mode underflow always lands on top
  assert_down_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_q && mode == MD_DOWN && $past(mode) == MD_DOWN && $stable(top)) |-> (cnt_q == top));

  // R3: an up/down overflow turns the count to top-1 heading down
  assert_updn_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && mode == MD_UPDN && $past(mode) == MD_UPDN && $stable(top)) |->
    (cnt_q == top - ONE && dir_down_o));

  // R9: a one-shot wrap leaves the counter stopped unless a command restarted it
  assert_oneshot_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_q || unf_q) && $past(oneshot) && $past(hw_act) == ACT_NONE && !$past(sw_start)) |-> !run_q);

  // R10: a stopped counter without a reload keeps its count
  assert_hold_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && hw_act != ACT_RELOAD) |=> (cnt_q == $past(cnt_q)));

  // R11: overflow and underflow never coincide
  assert_no_dual_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_q && unf_q));
endmodule

// File: rtl/mm_timer.sv
module mm_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PRESC_MAX = 10,
  parameter int PEXP_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_oneshot,
  input  logic [1:0]        cfg_src,
  input  logic [PEXP_W-1:0] cfg_presc_exp,
  input  logic [1:0]        cfg_ext_edge,
  input  logic [1:0]        cfg_act_rise,
  input  logic [1:0]        cfg_act_fall,
  input  logic [CNT_W-1:0]  cfg_top,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              ext_in,
  input  logic              ctl_in,
  input  logic              casc_in,
  output logic [CNT_W-1:0]  count_o,
  output logic              dir_down_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic tick;
  act_e hw_act;

  tmr_tick_gen #(.PRESC_MAX(PRESC_MAX), .PEXP_W(PEXP_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .src(src_e'(cfg_src)), .presc_exp(cfg_presc_exp),
    .ext_edge(edge_e'(cfg_ext_edge)), .ext_in(ext_in), .casc_in(casc_in), .tick(tick)
  );

  tmr_edge_ctl u_edge (
    .clk(clk), .rst_n(rst_n), .ctl_in(ctl_in), .act_rise(act_e'(cfg_act_rise)),
    .act_fall(act_e'(cfg_act_fall)), .hw_act(hw_act)
  );

  tmr_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode_e'(cfg_mode)), .oneshot(cfg_oneshot),
    .top(cfg_top), .tick(tick), .hw_act(hw_act), .sw_start(cmd_start), .sw_stop(cmd_stop),
    .cnt_o(count_o), .dir_down_o(dir_down_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );
endmodule

// File: tb/test_mm_timer.sv
module test_mm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        cfg_oneshot = 1'b0;
  logic [1:0]  cfg_src = 2'd0;
  logic [3:0]  cfg_presc_exp = 4'd0;
  logic [1:0]  cfg_ext_edge = 2'd0;
  logic [1:0]  cfg_act_rise = 2'd3;
  logic [1:0]  cfg_act_fall = 2'd0;
  logic [15:0] cfg_top = 16'd5;
  logic        cmd_start = 1'b0, cmd_stop = 1'b0;
  logic        ext_in = 1'b0, ctl_in = 1'b0, casc_in = 1'b0;
  logic [15:0] count_o;
  logic        dir_down_o, ovf_o, unf_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [15:0] held;

  mm_timer i_mm_timer (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_oneshot(cfg_oneshot),
    .cfg_src(cfg_src), .cfg_presc_exp(cfg_presc_exp), .cfg_ext_edge(cfg_ext_edge),
    .cfg_act_rise(cfg_act_rise), .cfg_act_fall(cfg_act_fall), .cfg_top(cfg_top),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .ext_in(ext_in), .ctl_in(ctl_in),
    .casc_in(casc_in), .count_o(count_o), .dir_down_o(dir_down_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  always #5 clk = ~clk;

  // fields: mode[42:41] top[40:25] steps[24:17] expected count[16:1] expected dir[0]
  localparam int NV = 13;
  localparam logic [42:0] VEC [NV] = '{
    {2'd0, 16'd5, 8'd0, 16'd0, 1'b0},   // R8 reload to 0
    {2'd0, 16'd5, 8'd3, 16'd3, 1'b0},
    {2'd0, 16'd5, 8'd6, 16'd0, 1'b0},
    {2'd0, 16'd5, 8'd8, 16'd2, 1'b0},
    {2'd0, 16'd0, 8'd4, 16'd0, 1'b0},
    {2'd1, 16'd9, 8'd0, 16'd9, 1'b1},   // R8 reload to top
    {2'd1, 16'd5, 8'd2, 16'd3, 1'b1},
    {2'd1, 16'd5, 8'd6, 16'd5, 1'b1},
    {2'd1, 16'd5, 8'd7, 16'd4, 1'b1},
    {2'd2, 16'd3, 8'd3, 16'd3, 1'b0},
    {2'd2, 16'd3, 8'd4, 16'd2, 1'b1},
    {2'd2, 16'd3, 8'd6, 16'd0, 1'b1},
    {2'd2, 16'd3, 8'd7, 16'd1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  // rising ctl_in edge with reload action; returns at the negedge after the reload edge
  task automatic reload_go(input logic [1:0] m, input logic [15:0] t);
    @(negedge clk);
    cfg_act_rise = 2'd3;
    cfg_act_fall = 2'd0;
    cfg_mode = m;
    cfg_top  = t;
    ctl_in   = 1'b1;
    @(negedge clk);
    ctl_in = 1'b0;
  endtask

  task automatic pulse_ext(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_in = 1'b1;
      @(negedge clk); ext_in = 1'b0;
    end
    @(negedge clk);
  endtask

  function automatic string mode_req(input logic [1:0] m);
    return (m == 2'd0) ? "R1" : (m == 2'd1) ? "R2" : "R3";
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 reset count", count_o, 0);
    check("R11 reset ovf", ovf_o, 0);
    check("R11 reset unf", unf_o, 0);
    check("R11 reset dir", dir_down_o, 0);
    repeat (5) @(negedge clk);
    check("R10 idle after reset", count_o, 0);

    // table walk: divider exponent 0, one tick per cycle
    for (int v = 0; v < NV; v++) begin
      reload_go(VEC[v][42:41], VEC[v][40:25]);
      repeat (int'(VEC[v][24:17])) @(negedge clk);
      check({mode_req(VEC[v][42:41]), " count"}, count_o, VEC[v][16:1]);
      check({mode_req(VEC[v][42:41]), " dir"}, dir_down_o, VEC[v][0]);
    end

    // R1 / R11: overflow pulse aligned with wrapped count, one cycle wide
    reload_go(2'd0, 16'd2);
    repeat (3) @(negedge clk);
    check("R1 ovf at wrap", ovf_o, 1);
    check("R11 count with ovf", count_o, 0);
    @(negedge clk);
    check("R11 ovf single cycle", ovf_o, 0);
    check("R1 count after wrap", count_o, 1);

    // R2 underflow
    reload_go(2'd1, 16'd2);
    repeat (3) @(negedge clk);
    check("R2 unf at wrap", unf_o, 1);
    check("R2 count at wrap", count_o, 2);
    check("R11 no ovf in down", ovf_o, 0);

    // R3 turn points
    reload_go(2'd2, 16'd2);
    repeat (3) @(negedge clk);
    check("R3 ovf at top turn", ovf_o, 1);
    check("R3 count at top turn", count_o, 1);
    check("R3 dir after top turn", dir_down_o, 1);
    repeat (2) @(negedge clk);
    check("R3 unf at bottom turn", unf_o, 1);
    check("R3 count at bottom turn", count_o, 1);
    check("R3 dir after bottom turn", dir_down_o, 0);

    // R9 one-shot
    cfg_oneshot = 1'b1;
    reload_go(2'd0, 16'd2);
    repeat (3) @(negedge clk);
    check("R9 oneshot wrap ovf", ovf_o, 1);
    repeat (3) @(negedge clk);
    check("R9 oneshot stays stopped", count_o, 0);

    // R10 software start: run set at the edge, first step one edge later
    cfg_oneshot = 1'b0;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    check("R10 start edge no step", count_o, 0);
    @(negedge clk);
    check("R10 first step after start", count_o, 1);

    // R10 software stop
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0;
    held = count_o;
    repeat (3) @(negedge clk);
    check("R10 hold after stop", count_o, held);

    // R10 priority: hardware stop versus software start in the same cycle
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    cfg_top = 16'd1000;
    reload_go(2'd0, 16'd1000);
    repeat (2) @(negedge clk);
    cfg_act_rise = 2'd2;
    ctl_in = 1'b1;
    cmd_start = 1'b1;
    @(negedge clk);
    ctl_in = 1'b0;
    cmd_start = 1'b0;
    held = count_o;
    repeat (3) @(negedge clk);
    check("R10 hardware stop beats start", count_o, held);

    // R7 falling-edge start without reload
    cfg_act_rise = 2'd0;
    cfg_act_fall = 2'd1;
    ctl_in = 1'b1;
    @(negedge clk);
    ctl_in = 1'b0;
    @(negedge clk);
    check("R7 fall start keeps count", count_o, held);
    @(negedge clk);
    check("R7 counting after fall start", count_o, held + 16'd1);

    // R4 divider
    cfg_presc_exp = 4'd2;
    reload_go(2'd0, 16'd1000);
    repeat (16) @(negedge clk);
    check("R4 divide by 4", count_o, 4);
    cfg_presc_exp = 4'd12;
    reload_go(2'd0, 16'd1000);
    repeat (1024) @(negedge clk);
    check("R4 exponent clipped to 10", count_o, 1);
    cfg_presc_exp = 4'd0;

    // R5 external edges
    cfg_src = 2'd1;
    cfg_ext_edge = 2'd0;
    reload_go(2'd0, 16'd1000);
    pulse_ext(3);
    check("R5 rising edges", count_o, 3);
    cfg_ext_edge = 2'd1;
    reload_go(2'd0, 16'd1000);
    pulse_ext(3);
    check("R5 falling edges", count_o, 3);
    cfg_ext_edge = 2'd2;
    reload_go(2'd0, 16'd1000);
    pulse_ext(3);
    check("R5 both edges", count_o, 6);

    // R6 neighbour pulses
    cfg_src = 2'd2;
    reload_go(2'd0, 16'd1000);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); casc_in = 1'b1;
      @(negedge clk); casc_in = 1'b0;
      @(negedge clk);
    end
    check("R6 cascade ticks", count_o, 5);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule